// File: doc/BRIEF.md
# Coarse Timestamp and Periodic Tick Unit

This block keeps one free-running 56-bit count of reference-clock cycles. It serves three consumers: a logging path, a tagging path and an address-translation aging path. Each consumer sees its own reduced-resolution copy of the count, taken by shifting the count right by a programmable number of bits. The logging copy can instead show a count of elapsed milliseconds. The block runs in the reference-clock domain, and one clock cycle stands for one reference tick.

A programmable divider turns the reference into a slower common timer clock, which is carried as a one-cycle enable strobe. Three tick generators count common-clock strobes. Each one raises a one-cycle tick once per selected period, and each generator has its own period. Software programs the block through a write-only port that has three word addresses. To reprogram the divider, software first writes it disabled, then writes the new value with the enable set.

Top module: `tstamp_pulse_unit`

## Requirements
- R1: While the synchronous active-low reset is asserted, and in the first cycle after it, all three timestamp outputs and all tick outputs are zero. All shift fields, the logging select, the divider value and enable, and all granularity codes reset to zero.
- R2: The base count rises by exactly one on every clock edge outside reset, modulo 2^56. With a shift of 0, a timestamp output equals the number of clock edges since reset was released, truncated to the output width.
- R3: Register word 0 holds the timestamp configuration: logging shift in bits [5:0], logging select in bit 6, tag shift in bits [13:8], NAT shift in bits [21:16]. The tag and NAT outputs equal the base count shifted right by their field, truncated to the output width, from the cycle after the write onward.
- R4: When the logging select is 1, the logging output is the base count shifted right by the logging shift. When it is 0, the logging output is the number of whole milliseconds since reset: the edges since reset divided by REF_PER_MS, rounded down.
- R5: Register word 1 holds the divider: divide value in bits [15:0] and enable in bit 31. With value N and the enable set, one common strobe occurs every N+1 cycles. A generator with period P common ticks raises its first tick exactly P*(N+1) cycles after the enabling write edge, and raises one again every P*(N+1) cycles after that.
- R6: Register word 2 holds the granularity codes: generator g uses bits [2g+1:2g]. Codes 0, 1, 2 and 3 select 10, 100, 1000 and 10000 common ticks. Every tick is high for exactly one cycle.
- R7: While the divider enable is 0, no tick is raised, up to the cycle after the disabling write edge. When the divider is enabled again, the divider and all generators count from zero, so the timing of R5 applies again.
- R8: A write to word 2 restarts only those generators whose code changes. A restarted generator raises its first tick one full new period after the write edge. A generator whose code is written with the same value keeps its phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; each edge is one reference tick |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word select (0 timestamps, 1 divider, 2 granularity) |
| wr_data | input | DATA_W (32) | Register write data |
| ts_log | output | TS_W (32) | Logging timestamp |
| ts_tag | output | TS_W (32) | Tag timestamp |
| ts_nat | output | TS_W (32) | NAT aging timestamp |
| tick | output | 3 | One-cycle tick strobe per generator |

## Verification
The checks assume that software never changes the divide value while the enable stays set. Any new value is written either with the enable cleared or while the divider is already disabled. The bench keeps to this by always writing a disable word before it loads a new divide value. The checks also assume that writes arrive as single-cycle strobes in the clock domain. Address 3 is never used. The bench drives each write at a falling edge, holds it for one full cycle, and uses only words 0 to 2.

// File: rtl/tsu_pkg.sv
// Shared constants, register word selects and the granularity decode
// for the timestamp and tick unit.
package tsu_pkg;
    localparam int NUM_GEN     = 3;
    localparam int GRAN_W      = 2;
    localparam int SHIFT_W     = 6;
    localparam int BASE_PERIOD = 10;
    localparam int MAX_PERIOD  = BASE_PERIOD * 1000;
    localparam int PCNT_W      = $clog2(MAX_PERIOD);

    typedef enum logic [1:0] {
        REG_STAMP = 2'd0,
        REG_DIV   = 2'd1,
        REG_GRAN  = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [SHIFT_W-1:0] log_shift;
        logic               log_sel;
        logic [SHIFT_W-1:0] tag_shift;
        logic [SHIFT_W-1:0] nat_shift;
    } stamp_cfg_t;

    // Period in common ticks for a granularity code: BASE_PERIOD * 10^code.
    function automatic logic [PCNT_W-1:0] gran_period(input logic [GRAN_W-1:0] code);
        int p;
        p = BASE_PERIOD;
        for (int i = 0; i < 3; i++) begin
            if (i < int'(code)) p = p * 10;
        end
        return PCNT_W'(p);
    endfunction
endpackage

// File: rtl/tsu_regs.sv
// Write-only configuration registers. Decodes three word addresses.
// Each generator gets a restart pulse when its granularity code changes.
// Assumes single-cycle write strobes in the clk domain.
module tsu_regs
    import tsu_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int DATA_W = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [1:0]                      wr_addr,
    input  logic [DATA_W-1:0]               wr_data,
    output stamp_cfg_t                      cfg,
    output logic [DIV_W-1:0]                div_val,
    output logic                            div_en,
    output logic [NUM_GEN-1:0][GRAN_W-1:0]  gran,
    output logic [NUM_GEN-1:0]              restart
);
    localparam int LOG_SH_LSB  = 0;
    localparam int LOG_SEL_BIT = 6;
    localparam int TAG_SH_LSB  = 8;
    localparam int NAT_SH_LSB  = 16;
    localparam int EN_BIT      = DATA_W - 1;
    localparam int GRAN_STRIDE = 2;

    logic hit_stamp, hit_div, hit_gran;
    logic unused_bits;

    assign hit_stamp   = wr_en && (wr_addr == REG_STAMP);
    assign hit_div     = wr_en && (wr_addr == REG_DIV);
    assign hit_gran    = wr_en && (wr_addr == REG_GRAN);
    assign unused_bits = ^wr_data[EN_BIT-1:NAT_SH_LSB+SHIFT_W];

    // Timestamp shift and select fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (hit_stamp) begin
            cfg.log_shift <= wr_data[LOG_SH_LSB +: SHIFT_W];
            cfg.log_sel   <= wr_data[LOG_SEL_BIT];
            cfg.tag_shift <= wr_data[TAG_SH_LSB +: SHIFT_W];
            cfg.nat_shift <= wr_data[NAT_SH_LSB +: SHIFT_W];
        end
    end

    // Divider value and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_val <= '0;
            div_en  <= 1'b0;
        end else if (hit_div) begin
            div_val <= wr_data[DIV_W-1:0];
            div_en  <= wr_data[EN_BIT];
        end
    end

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gran
        // Restart request when this generator's code is written with a new value.
        assign restart[g] = hit_gran && (wr_data[g*GRAN_STRIDE +: GRAN_W] != gran[g]);

        // Granularity code of generator g.
        always_ff @(posedge clk) begin
            if (!rst_n)        gran[g] <= '0;
            else if (hit_gran) gran[g] <= wr_data[g*GRAN_STRIDE +: GRAN_W];
        end
    end

    // R5: the divide value must not change while the divider stays enabled.
    assert_div_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_div && div_en && wr_data[EN_BIT]) |-> (wr_data[DIV_W-1:0] == div_val));
endmodule

// File: rtl/tsu_stamp.sv
// Free-running base count, millisecond count and three right-shifted
// coarse views of the base count. The logging view can show the
// millisecond count instead. One clk cycle is one reference tick.
module tsu_stamp
    import tsu_pkg::*;
#(
    parameter int CNT_W      = 56,
    parameter int TS_W       = 32,
    parameter int REF_PER_MS = 19200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  stamp_cfg_t       cfg,
    output logic [TS_W-1:0]  ts_log,
    output logic [TS_W-1:0]  ts_tag,
    output logic [TS_W-1:0]  ts_nat
);
    localparam int N_CONS = 3;
    localparam int PRE_W  = $clog2(REF_PER_MS);

    logic [CNT_W-1:0]                 cnt_q;
    logic [PRE_W-1:0]                 pre_q;
    logic [TS_W-1:0]                  ms_q;
    logic [N_CONS-1:0][SHIFT_W-1:0]   sh;
    logic [N_CONS-1:0][TS_W-1:0]      coarse;

    assign sh = {cfg.nat_shift, cfg.tag_shift, cfg.log_shift};

    // Base count, wraps modulo 2^CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Millisecond prescaler and millisecond count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (pre_q == PRE_W'(REF_PER_MS - 1)) begin
            pre_q <= '0;
            ms_q  <= ms_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    for (genvar i = 0; i < N_CONS; i++) begin : g_cons
        assign coarse[i] = TS_W'(cnt_q >> sh[i]);
    end

    assign ts_log = cfg.log_sel ? coarse[0] : ms_q;
    assign ts_tag = coarse[1];
    assign ts_nat = coarse[2];

    // R2: the base count advances by exactly one per edge.
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

    // R4: the millisecond count never jumps by more than one.
    assert_ms_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ms_q == $past(ms_q)) || (ms_q == TS_W'($past(ms_q) + 1'b1))));
endmodule

// File: rtl/tsu_div.sv
// Common timer clock divider. Raises a one-cycle strobe every val+1
// cycles while enabled. Held at zero while disabled, so it restarts
// from zero on enable. Assumes val is stable while enabled.
module tsu_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] val,
    output logic             ctick
);
    logic [DIV_W-1:0] cnt_q;
    logic             at_top;

    assign at_top = (cnt_q >= val);
    assign ctick  = en && at_top;

    // Divider count: clears when disabled or at the top, else counts up.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) cnt_q <= '0;
        else if (at_top)   cnt_q <= '0;
        else               cnt_q <= cnt_q + 1'b1;
    end

    // R5: the count stays within the programmed range while enabled.
    assert_div_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt_q <= val));

    // R7: counting starts from zero when the divider is enabled.
    assert_div_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (cnt_q == '0));
endmodule

// File: rtl/tsu_pulse.sv
// One tick generator. Counts common strobes and raises a registered
// one-cycle tick once per selected period. Cleared while the divider
// is disabled and on a restart request.
module tsu_pulse
    import tsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ctick,
    input  logic              restart,
    input  logic [GRAN_W-1:0] code,
    output logic              tick
);
    logic [PCNT_W-1:0] cnt_q;
    logic [PCNT_W-1:0] last;
    logic              wrap;

    assign last = gran_period(code) - 1'b1;
    assign wrap = (cnt_q >= last);

    // Period count and registered tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en || restart) begin
            cnt_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= ctick && wrap;
            if (ctick) cnt_q <= wrap ? '0 : cnt_q + 1'b1;
        end
    end

    // R6: a tick lasts exactly one cycle.
    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R7: no tick follows a cycle with the divider disabled.
    assert_tick_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !tick);

    // R5: every tick is caused by a common strobe in the cycle before.
    assert_tick_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tick) |-> $past(ctick));
endmodule

// File: rtl/tstamp_pulse_unit.sv
// Top of the timestamp and tick unit. Ties together the register file,
// the timestamp views, the common divider and the tick generators.
// Everything runs on the reference clock.
module tstamp_pulse_unit
    import tsu_pkg::*;
#(
    parameter int CNT_W      = 56,
    parameter int TS_W       = 32,
    parameter int DIV_W      = 16,
    parameter int REF_PER_MS = 19200,
    parameter int DATA_W     = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic [TS_W-1:0]    ts_log,
    output logic [TS_W-1:0]    ts_tag,
    output logic [TS_W-1:0]    ts_nat,
    output logic [NUM_GEN-1:0] tick
);
    stamp_cfg_t                      cfg;
    logic [DIV_W-1:0]                div_val;
    logic                            div_en;
    logic [NUM_GEN-1:0][GRAN_W-1:0]  gran;
    logic [NUM_GEN-1:0]              restart;
    logic                            ctick;

    tsu_regs #(.DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cfg(cfg), .div_val(div_val), .div_en(div_en),
        .gran(gran), .restart(restart)
    );

    tsu_stamp #(.CNT_W(CNT_W), .TS_W(TS_W), .REF_PER_MS(REF_PER_MS)) u_stamp (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .ts_log(ts_log), .ts_tag(ts_tag), .ts_nat(ts_nat)
    );

    tsu_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .en(div_en), .val(div_val), .ctick(ctick)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
        tsu_pulse u_pulse (
            .clk(clk), .rst_n(rst_n), .en(div_en), .ctick(ctick),
            .restart(restart[g]), .code(gran[g]), .tick(tick[g])
        );
    end
endmodule

// File: tb/sim_tstamp_pulse_unit.sv
`timescale 1ns/1ps
module sim_tstamp_pulse_unit;
    localparam int REF_MS = 50;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = 2'd0;
    logic [31:0] wr_data = 32'd0;
    logic [31:0] ts_log, ts_tag, ts_nat;
    logic [2:0]  tick;

    int     errors = 0;
    int     checks = 0;
    longint cyc = 0;
    logic [55:0] m = '0;
    bit     done = 1'b0;
    string  phase = "R5";
    longint q0[$], q1[$], q2[$];

    tstamp_pulse_unit #(.REF_PER_MS(REF_MS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ts_log(ts_log), .ts_tag(ts_tag),
        .ts_nat(ts_nat), .tick(tick)
    );

    always #2.5 clk = ~clk;

    // Cycle count and reference model of the base count (R2).
    always @(posedge clk) begin
        cyc <= cyc + 1;
        m   <= rst_n ? m + 1'b1 : '0;
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int qsize(input int g);
        case (g)
            0: return q0.size();
            1: return q1.size();
            default: return q2.size();
        endcase
    endfunction

    function automatic longint qfront(input int g);
        case (g)
            0: return q0[0];
            1: return q1[0];
            default: return q2[0];
        endcase
    endfunction

    task automatic qpop(input int g);
        case (g)
            0: void'(q0.pop_front());
            1: void'(q1.pop_front());
            default: void'(q2.pop_front());
        endcase
    endtask

    task automatic qpush(input int g, input longint t);
        case (g)
            0: q0.push_back(t);
            1: q1.push_back(t);
            default: q2.push_back(t);
        endcase
    endtask

    // Push the expected tick cycles of generator g, period t, from base up to last.
    task automatic expect_ticks(input int g, input longint base, input longint t, input longint last);
        for (longint c = base + t; c <= last; c += t) qpush(g, c);
    endtask

    // Monitor for one generator: compares observed ticks with the queue.
    task automatic mon_one(input int g);
        if (qsize(g) > 0 && qfront(g) < cyc) begin
            check(phase, $sformatf("missed tick gen%0d", g), cyc, qfront(g));
            qpop(g);
        end
        if (tick[g]) begin
            if (qsize(g) == 0) begin
                check(phase, $sformatf("unexpected tick gen%0d", g), 1, 0);
            end else begin
                check(phase, $sformatf("tick cycle gen%0d", g), cyc, qfront(g));
                qpop(g);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int g = 0; g < 3; g++) mon_one(g);
        end
    end

    // Register write: called at a falling edge, captured at the next rising edge.
    task automatic wr(input logic [1:0] a, input logic [31:0] d, output longint e);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        e = cyc;
    endtask

    task automatic wait_until(input longint c);
        while (cyc < c) @(negedge clk);
    endtask

    function automatic logic [31:0] stamp_word(input int ls, input int sel, input int ts, input int ns);
        return 32'(ls) | (32'(sel) << 6) | (32'(ts) << 8) | (32'(ns) << 16);
    endfunction

    function automatic logic [31:0] div_word(input int v, input int en);
        return 32'(v) | (32'(en) << 31);
    endfunction

    function automatic logic [31:0] gran_word(input int c0, input int c1, input int c2);
        return 32'(c0) | (32'(c1) << 2) | (32'(c2) << 4);
    endfunction

    task automatic check_stamps(input string tag, input int ls, input int sel, input int ts, input int ns);
        logic [31:0] exp_log;
        exp_log = sel ? 32'(m >> ls) : 32'(m / REF_MS);
        check(sel ? "R4" : "R4", {tag, " log"}, ts_log, exp_log);
        check(ts == 0 ? "R2" : "R3", {tag, " tag"}, ts_tag, 32'(m >> ts));
        check("R3", {tag, " nat"}, ts_nat, 32'(m >> ns));
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        longint e0, e1, eg, e2, ed;
        int n;
        // R1: reset state.
        repeat (4) @(negedge clk);
        check("R1", "ts_log in reset", ts_log, 0);
        check("R1", "ts_tag in reset", ts_tag, 0);
        check("R1", "ts_nat in reset", ts_nat, 0);
        check("R1", "tick in reset", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "tick after reset", tick, 0);
        check("R1", "ts_log after reset", ts_log, 0);

        // R2/R3/R4: shift 0 on tag, 24 on nat, millisecond logging.
        repeat (3) @(negedge clk);
        wr(2'd0, stamp_word(0, 0, 0, 24), ed);
        check_stamps("cfgA t0", 0, 0, 0, 24);
        repeat (137) @(negedge clk);
        check_stamps("cfgA t1", 0, 0, 0, 24);
        check("R4", "ms count nonzero", (ts_log != 0), 1);

        // R3/R4: shifted logging and other shifts.
        wr(2'd0, stamp_word(3, 1, 4, 1), ed);
        check_stamps("cfgB t0", 3, 1, 4, 1);
        repeat (59) @(negedge clk);
        check_stamps("cfgB t1", 3, 1, 4, 1);

        // R7: codes set, divider still disabled, no ticks.
        wr(2'd2, gran_word(0, 1, 2), ed);
        phase = "R7";
        n = 0;
        repeat (60) begin @(negedge clk); n += $countones(tick); end
        check("R7", "ticks with divider off", n, 0);

        // R5/R6: divide by 2; periods 10, 100, 1000 common ticks.
        phase = "R5";
        wr(2'd1, div_word(1, 1), e0);
        expect_ticks(0, e0, 20, e0 + 450);
        expect_ticks(1, e0, 200, e0 + 450);
        wait_until(e0 + 449);
        wr(2'd1, div_word(1, 0), ed);
        check("R7", "disable edge", ed, e0 + 450);
        phase = "R7";
        n = 0;
        repeat (300) begin @(negedge clk); n += $countones(tick); end
        check("R7", "ticks after disable", n, 0);

        // R7/R8: re-enable at divide by 1; restart from zero; change gen0 code only.
        phase = "R8";
        wr(2'd1, div_word(0, 1), e1);
        expect_ticks(0, e1, 10, e1 + 205);
        expect_ticks(1, e1, 100, e1 + 1050);
        expect_ticks(2, e1, 1000, e1 + 1050);
        wait_until(e1 + 204);
        wr(2'd2, gran_word(1, 1, 2), eg);
        check("R8", "gran write edge", eg, e1 + 205);
        expect_ticks(0, eg, 100, e1 + 1050);
        wait_until(e1 + 1049);
        wr(2'd1, div_word(0, 0), ed);
        check("R8", "second disable edge", ed, e1 + 1050);
        repeat (20) @(negedge clk);

        // R6: longest period (code 3 = 10000 common ticks) on gen2.
        phase = "R6";
        wr(2'd2, gran_word(1, 1, 3), ed);
        wr(2'd1, div_word(0, 1), e2);
        expect_ticks(0, e2, 100, e2 + 10050);
        expect_ticks(1, e2, 100, e2 + 10050);
        expect_ticks(2, e2, 10000, e2 + 10050);
        wait_until(e2 + 10049);
        wr(2'd1, div_word(0, 0), ed);
        phase = "R7";
        n = 0;
        repeat (200) begin @(negedge clk); n += $countones(tick); end
        check("R7", "ticks after final disable", n, 0);
        check("R5", "pending gen0", q0.size(), 0);
        check("R5", "pending gen1", q1.size(), 0);
        check("R6", "pending gen2", q2.size(), 0);
        check_stamps("cfgB end", 3, 1, 4, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule